// File: doc/BRIEF.md
# Interleaved Structure Access Sequencer

This block turns one multi-register structure transfer command into the ordered list of single-element memory accesses it implies. A command names a structure type, an element size, a first vector register, a base byte address and a direction. The sequencer walks memory strictly upward, one element per access. For each access it derives the 64-bit vector register and the lane that the element belongs to, so that consecutive memory elements are spread across registers in interleaved order.

Each structure type has its own shape: a number of register groups, an interleave factor and a register spacing. The walk runs over group (outermost), then lane, then interleave slot (innermost). Commands arrive over a valid/ready handshake. Accesses leave over a second valid/ready handshake. The sequencer also reports illegal commands, and it reports the total byte count, which the caller uses to post-increment the base register.

Both handshakes follow the same back-pressure rules. A command is taken in a cycle where `start_valid` and `start_ready` are both high. An access is consumed in a cycle where `acc_valid` and `acc_ready` are both high. While `acc_ready` is low, the access on offer is held unchanged.

Top module: `struct_seq`

## Requirements
- R1: `start_ready` is high exactly when no sequence is in progress. A command is accepted on a clock edge where `start_valid` and `start_ready` are both high.
- R2: The structure type code maps to a triple (groups, interleave, spacing) as follows:
  - 0 = (1,4,1)
  - 1 = (1,4,2)
  - 2 = (4,1,1)
  - 3 = (2,2,2)
  - 4 = (1,3,1)
  - 5 = (1,3,2)
  - 6 = (3,1,1)
  - 7 = (1,1,1)
  - 8 = (1,2,1)
  - 9 = (1,2,2)
  - 10 = (2,1,1)
- R3: With size code s, each register holds 8>>s lanes. Accesses are issued in loop order: group g from 0, then lane n from 0, then interleave slot x from 0, with x varying fastest. The number of accesses is groups*(8>>s)*interleave.
- R4: Each access targets register (base_reg + g + spacing*x) mod 32 and lane n. `acc_reg_wrap` is high when the unreduced sum is 32 or more.
- R5: The first access address equals the command base address. Each later address is the previous one plus 1<<s bytes.
- R6: While `acc_valid` is high and `acc_ready` is low, `acc_valid` stays high and every access field holds its value into the next cycle.
- R7: `done` is high for exactly one cycle, in the cycle after the final access handshake. After that the sequencer is idle again.
- R8: Size code 3 with a type whose interleave or spacing is not 1 is illegal. Such a command pulses `err` for one cycle, in the cycle after acceptance, and produces no access.
- R9: Type codes 11 to 15 are illegal and behave as in R8.
- R10: From the cycle after a legal command is accepted, `total_bytes` equals groups*interleave*8, and it holds that value until the next legal command.
- R11: Every access carries `acc_size` equal to the command size code and `acc_is_load` equal to the command direction flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Command offered |
| start_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_type | input | 4 | Structure type code |
| cmd_size | input | 2 | Element size code, 1<<s bytes |
| cmd_base_reg | input | 5 | First vector register |
| cmd_base_addr | input | AW | Base byte address |
| cmd_is_load | input | 1 | 1 = load, 0 = store |
| acc_valid | output | 1 | Access offered |
| acc_ready | input | 1 | Downstream takes the access |
| acc_addr | output | AW | Byte address of the access |
| acc_reg | output | 5 | Target vector register |
| acc_lane | output | 3 | Lane within the register |
| acc_size | output | 2 | Element size code |
| acc_is_load | output | 1 | Direction of the access |
| acc_reg_wrap | output | 1 | Register index wrapped past 31 |
| done | output | 1 | One-cycle pulse after the last access |
| err | output | 1 | One-cycle pulse for an illegal command |
| total_bytes | output | 6 | Writeback byte count |

## Verification
The assertions assume that `rst_n` is held low across at least one clock edge before any handshake. They also assume that command fields only matter in the cycle the command is accepted. The stimulus drives every input on the falling edge and holds commands stable only for that accepting cycle. It toggles `acc_ready` in some runs, so stall cycles fall in the middle of a sequence as well as at its end.

// File: rtl/struct_seq_pkg.sv
package struct_seq_pkg;

  // Shape of one structure type: register groups, interleave factor, register spacing.
  typedef struct packed {
    logic [2:0] groups;
    logic [2:0] ilv;
    logic [1:0] spc;
  } shape_t;

  function automatic shape_t shape_of(input logic [3:0] code);
    shape_t s;
    case (code)
      4'd0:    s = '{groups: 3'd1, ilv: 3'd4, spc: 2'd1};
      4'd1:    s = '{groups: 3'd1, ilv: 3'd4, spc: 2'd2};
      4'd2:    s = '{groups: 3'd4, ilv: 3'd1, spc: 2'd1};
      4'd3:    s = '{groups: 3'd2, ilv: 3'd2, spc: 2'd2};
      4'd4:    s = '{groups: 3'd1, ilv: 3'd3, spc: 2'd1};
      4'd5:    s = '{groups: 3'd1, ilv: 3'd3, spc: 2'd2};
      4'd6:    s = '{groups: 3'd3, ilv: 3'd1, spc: 2'd1};
      4'd7:    s = '{groups: 3'd1, ilv: 3'd1, spc: 2'd1};
      4'd8:    s = '{groups: 3'd1, ilv: 3'd2, spc: 2'd1};
      4'd9:    s = '{groups: 3'd1, ilv: 3'd2, spc: 2'd2};
      4'd10:   s = '{groups: 3'd2, ilv: 3'd1, spc: 2'd1};
      default: s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/struct_seq_decode.sv
module struct_seq_decode
  import struct_seq_pkg::*;
(
  input  logic [3:0] code,
  input  logic [1:0] size,
  output shape_t     shape,
  output logic [2:0] lanes_m1,
  output logic [5:0] bytes,
  output logic       illegal
);
  logic [5:0] prod;

  always_comb begin
    shape    = shape_of(code);
    lanes_m1 = 3'd7 >> size;
    prod     = 6'(shape.groups) * 6'(shape.ilv);
    bytes    = {prod[2:0], 3'b000};
    illegal  = (code > 4'd10) ||
               ((size == 2'd3) && ((shape.ilv != 3'd1) || (shape.spc != 2'd1)));
  end

  // Immediate check: a legal code always yields a non-empty shape.
  always_comb begin
    if (!illegal) begin
      AST_SHAPE_NONZERO: assert (shape.groups != 3'd0 && shape.ilv != 3'd0); // R2
    end
  end
endmodule

// File: rtl/struct_seq_walk.sv
module struct_seq_walk (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic       step,
  input  logic [2:0] groups,
  input  logic [2:0] ilv,
  input  logic [2:0] lanes_m1,
  output logic [2:0] g,
  output logic [2:0] n,
  output logic [2:0] x,
  output logic       last
);
  logic x_end, n_end, g_end;

  assign x_end = (x == ilv - 3'd1);
  assign n_end = (n == lanes_m1);
  assign g_end = (g == groups - 3'd1);
  assign last  = x_end && n_end && g_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g <= '0;
      n <= '0;
      x <= '0;
    end else if (init) begin
      g <= '0;
      n <= '0;
      x <= '0;
    end else if (step) begin
      if (!x_end) begin
        x <= x + 3'd1;
      end else begin
        x <= '0;
        if (!n_end) begin
          n <= n + 3'd1;
        end else begin
          n <= '0;
          g <= g + 3'd1;
        end
      end
    end
  end

  AST_LANE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (n <= lanes_m1 && x < ilv)); // R3
endmodule

// File: rtl/struct_seq.sv
module struct_seq
  import struct_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_valid,
  output logic          start_ready,
  input  logic [3:0]    cmd_type,
  input  logic [1:0]    cmd_size,
  input  logic [RW-1:0] cmd_base_reg,
  input  logic [AW-1:0] cmd_base_addr,
  input  logic          cmd_is_load,
  output logic          acc_valid,
  input  logic          acc_ready,
  output logic [AW-1:0] acc_addr,
  output logic [RW-1:0] acc_reg,
  output logic [2:0]    acc_lane,
  output logic [1:0]    acc_size,
  output logic          acc_is_load,
  output logic          acc_reg_wrap,
  output logic          done,
  output logic          err,
  output logic [5:0]    total_bytes
);
  localparam int SW = RW + 2;

  shape_t     d_shape, r_shape;
  logic [2:0] d_lanes_m1, r_lanes_m1;
  logic [5:0] d_bytes;
  logic       d_illegal;
  logic       busy, accept, fire, last;
  logic [2:0] g, n, x;
  logic [RW-1:0] r_base;
  logic [SW-1:0] reg_sum;

  struct_seq_decode u_dec (
    .code(cmd_type), .size(cmd_size), .shape(d_shape),
    .lanes_m1(d_lanes_m1), .bytes(d_bytes), .illegal(d_illegal)
  );

  assign start_ready = !busy;
  assign accept      = start_valid && !busy;
  assign fire        = busy && acc_ready;

  struct_seq_walk u_walk (
    .clk(clk), .rst_n(rst_n), .init(accept), .step(fire),
    .groups(r_shape.groups), .ilv(r_shape.ilv), .lanes_m1(r_lanes_m1),
    .g(g), .n(n), .x(x), .last(last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      r_shape     <= '0;
      r_lanes_m1  <= '0;
      r_base      <= '0;
      acc_addr    <= '0;
      acc_size    <= '0;
      acc_is_load <= 1'b0;
      total_bytes <= '0;
      done        <= 1'b0;
      err         <= 1'b0;
    end else begin
      done <= fire && last;
      err  <= accept && d_illegal;
      if (accept && !d_illegal) begin
        busy        <= 1'b1;
        r_shape     <= d_shape;
        r_lanes_m1  <= d_lanes_m1;
        r_base      <= cmd_base_reg;
        acc_addr    <= cmd_base_addr;
        acc_size    <= cmd_size;
        acc_is_load <= cmd_is_load;
        total_bytes <= d_bytes;
      end else if (fire) begin
        acc_addr <= acc_addr + (AW'(1) << acc_size);
        if (last) busy <= 1'b0;
      end
    end
  end

  assign acc_valid    = busy;
  assign reg_sum      = SW'(r_base) + SW'(g) + SW'(r_shape.spc) * SW'(x);
  assign acc_reg      = reg_sum[RW-1:0];
  assign acc_reg_wrap = |reg_sum[SW-1:RW];
  assign acc_lane     = n;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_ready) |=> (acc_valid && $stable(acc_addr) && $stable(acc_reg) && $stable(acc_lane))); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && !done && !last) |=> (acc_addr == $past(acc_addr) + (AW'(1) << acc_size))); // R5
  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !acc_valid); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!acc_valid && start_ready) ##1 !done); // R7
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> !acc_valid); // R1
endmodule

// File: tb/struct_seq_bench.sv
module struct_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 0, rst_n = 0;
  logic start_valid = 0, acc_ready = 0, cmd_is_load = 0;
  logic [3:0] cmd_type = 0;
  logic [1:0] cmd_size = 0;
  logic [4:0] cmd_base_reg = 0;
  logic [AW-1:0] cmd_base_addr = 0;
  logic start_ready, acc_valid, acc_is_load, acc_reg_wrap, done, err;
  logic [AW-1:0] acc_addr;
  logic [4:0] acc_reg;
  logic [2:0] acc_lane;
  logic [1:0] acc_size;
  logic [5:0] total_bytes;
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  struct_seq u_struct_seq (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected shape per R2, written from the requirement.
  task automatic shape(input int code, output int gr, output int il, output int sp);
    int t[11][3] = '{'{1,4,1},'{1,4,2},'{4,1,1},'{2,2,2},'{1,3,1},'{1,3,2},
                     '{3,1,1},'{1,1,1},'{1,2,1},'{1,2,2},'{2,1,1}};
    gr = t[code][0]; il = t[code][1]; sp = t[code][2];
  endtask

  task automatic send(input int code, input int sz, input int br, input int ba, input bit ld);
    @(negedge clk);
    cmd_type = 4'(code); cmd_size = 2'(sz); cmd_base_reg = 5'(br);
    cmd_base_addr = AW'(ba); cmd_is_load = ld; start_valid = 1;
    @(negedge clk);
    start_valid = 0;
  endtask

  // Runs one legal command and checks every access (R3, R4, R5, R6, R7, R10, R11).
  task automatic run_legal(input int code, input int sz, input int br, input int ba,
                           input bit ld, input bit stall);
    int gr, il, sp, lanes, addr, sum, wait_n;
    shape(code, gr, il, sp);
    lanes = 8 >> sz;
    addr = ba;
    chk(start_ready == 1, "R1", start_ready, 1);
    send(code, sz, br, ba, ld);
    chk(start_ready == 0, "R1", start_ready, 0);
    chk(total_bytes == gr*il*8, "R10", total_bytes, gr*il*8);
    for (int g = 0; g < gr; g++)
      for (int n = 0; n < lanes; n++)
        for (int x = 0; x < il; x++) begin
          sum = br + g + sp*x;
          wait_n = 0;
          forever begin
            acc_ready = stall ? cyc[0] : 1'b1;
            if (acc_valid && acc_ready) break;
            chk(acc_valid == 1, "R6", acc_valid, 1);
            @(negedge clk);
            wait_n++;
            if (wait_n > 50) begin chk(0, "R3 watchdog", 0, 1); return; end
          end
          chk(acc_addr == AW'(addr), "R5", acc_addr, addr);
          chk(acc_reg == 5'(sum % 32), "R4", acc_reg, sum % 32);
          chk(acc_reg_wrap == (sum >= 32), "R4 wrap", acc_reg_wrap, sum >= 32);
          chk(acc_lane == 3'(n), "R3", acc_lane, n);
          chk(acc_size == 2'(sz) && acc_is_load == ld, "R11", {acc_size, acc_is_load}, {sz[1:0], ld});
          addr += (1 << sz);
          @(negedge clk);
        end
    acc_ready = 0;
    chk(done == 1, "R7", done, 1);
    chk(acc_valid == 0 && start_ready == 1, "R7", acc_valid, 0);
    @(negedge clk);
    chk(done == 0, "R7 pulse", done, 0);
  endtask

  task automatic run_illegal(input int code, input int sz, input string req);
    logic [5:0] tb_prev = total_bytes;
    send(code, sz, 3, 'h100, 1);
    chk(err == 1, req, err, 1);
    chk(acc_valid == 0 && start_ready == 1, req, acc_valid, 0);
    chk(total_bytes == tb_prev, {req, " R10 hold"}, total_bytes, tb_prev);
    @(negedge clk);
    chk(err == 0 && acc_valid == 0, req, err, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(start_ready == 1 && acc_valid == 0 && done == 0 && err == 0, "R1 reset", acc_valid, 0);
        run_legal(7, 0, 4, 'h1000, 1, 0);   // R3 single register, byte lanes
        run_legal(0, 2, 8, 'h2000, 0, 0);   // R2 R3 four-way interleave, store
        run_legal(3, 1, 1, 'h3000, 1, 1);   // R6 stalls, type 3 stride-2 regs
        run_legal(2, 3, 10, 'h4000, 1, 0);  // legal 64-bit type
        run_legal(5, 0, 30, 'h5000, 0, 1);  // R4 wrap past 31
        run_legal(6, 2, 0, 'h6004, 1, 0);
        run_illegal(0, 3, "R8");
        run_illegal(9, 3, "R8");
        run_illegal(12, 0, "R9");
        run_illegal(15, 2, "R9");
      end
      begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule